// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges several independent reasons for resetting a chip into one active-low system reset, `sys_rst_n_o`. The reasons are: a power-on reset input, a supply comparator that reports whether the supply is above its trip level, a clock-failure flag from a clock detector, and a debounced external reset pin. Each reason has its own release delay, counted in cycles of the free-running reference clock `clk`. Any reason pulls the output low at once, through combinational gating. Release is always synchronous, through a two-stage release shifter.

A small byte-wide register port sets up the supply monitor. Software can disable the monitor, re-enable it, and choose whether it acts as a reset source. After power-on the monitor is both enabled and selected. A re-enabled monitor needs a settling window. If software selects the monitor as a source during that window, the block resets the system, because an unsettled comparator may report a false level. A sticky one-hot cause register records the reason for the most recent reset. Only power-on overwrites the configuration.

The comparator output and the write port are assumed to be synchronous to `clk`.

Top module: `rst_seq`

## Requirements
- R1: While `por_n_i` is low the output is low. After power-on, the monitor-control register at address 0x13 reads enable = 1 (bit 7). The source-select register at 0x14 reads 0x01. The cause register at 0x15 reads 0x01. The output goes high POR_CYC+2 edges after the last edge that sampled `por_n_i` low.
- R2: When the monitor is enabled, selected and settled, and `sup_ok_i` is 0, the output is low. It goes high 2 edges after the last edge that sampled `sup_ok_i` low. The cause register then reads 0x02 (bit 1 = supply monitor).
- R3: Once `osc_ready_i` has been sampled high on an earlier edge, a high `clk_fail_i` resets the system. The output goes high CLKF_CYC+POR_CYC+2 edges after the last edge that sampled it high. The cause register reads 0x04 (bit 2 = clock failure).
- R4: A high `clk_fail_i` before `osc_ready_i` has ever been sampled high has no effect on the output or on the cause register.
- R5: A low `pin_n_i` resets the system. The output goes high PIN_CYC+2 edges after the last edge that sampled the pin low. The cause register reads 0x08 (bit 3 = pin).
- R6: Register 0x13 works as follows. Bit 7 is the monitor enable and is read/write. Bit 6 is read-only and equals enable AND `sup_ok_i`. Bits 5 to 0 always read 0, and writes to them are ignored.
- R7: Register 0x14 bit 0 selects the monitor as a reset source, and bits 7 to 1 read 0. Register 0x15 is read-only and ignores writes. After any reset it holds exactly one set bit.
- R8: A write that changes 0x13 bit 7 from 0 to 1 starts a SETTLE_CYC-cycle settling window. A write that changes 0x14 bit 0 from 0 to 1 within d edges after that enable write resets the system when d ≤ SETTLE_CYC. That reset releases POR_CYC+2 edges after the write and sets the cause register to 0x02. A later selection causes no reset.
- R9: A new cause that arrives while a hold-off is counting restarts the count with the new cause's own length.
- R10: With the monitor disabled or deselected, a low `sup_ok_i` does not reset the system.
- R11: A low pin, or a qualifying low supply, drives the output low in the same cycle, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n_i | input | 1 | Power-on reset, active low, sampled on `clk` |
| sup_ok_i | input | 1 | Supply comparator: 1 = supply above threshold |
| osc_ready_i | input | 1 | Oscillator initialization finished |
| clk_fail_i | input | 1 | Clock-failure detect |
| pin_n_i | input | 1 | Debounced external reset pin level, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from `addr_i` |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
The bench sweeps the position of the monitor-select write across the whole settling window and one cycle past it. A design with an off-by-one settle count would reset on the first clean select, or would let the last unsettled one through. Release delays are counted exactly for every source and for several hold widths. An extra or missing release stage would therefore show up as a count one edge off. Retriggering during a hold, including a short pin cause that lands on a long clock-failure hold, exposes a counter that keeps counting instead of reloading. Clock failure before the oscillator is ready, writes to the reserved and read-only bits, and a low supply while the monitor is disabled or deselected each catch a design that fails to mask an input.

// File: rtl/rst_seq_pkg.sv
// Package: shared register addresses and cause-bit positions for the
// reset sequencer. Assumes an 8-bit register port.
package rst_seq_pkg;

    localparam logic [7:0] ADDR_MONCTL = 8'h13;
    localparam logic [7:0] ADDR_SRCSEL = 8'h14;
    localparam logic [7:0] ADDR_CAUSE  = 8'h15;

    localparam int CAUSE_W = 4;

    typedef enum logic [1:0] {
        SRC_POR = 2'd0,
        SRC_MON = 2'd1,
        SRC_CLK = 2'd2,
        SRC_PIN = 2'd3
    } src_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rst_seq_ctrl.sv
// Module: rst_seq_ctrl
// Holds the monitor enable, monitor select, settling timer and the
// oscillator-seen flag. Produces the one-cycle event for selecting an
// unsettled monitor, and the gated clock-failure request.
// Assumes all inputs are synchronous to clk; por_n is a synchronous reset.
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 2000
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wr_en,
    input  logic [7:0]         addr,
    input  logic [7:0]         wdata,
    input  logic               sup_ok,
    input  logic               osc_ready,
    input  logic               clk_fail,
    input  logic [CAUSE_W-1:0] cause,
    output logic [7:0]         rdata,
    output logic               mon_en,
    output logic               mon_sel,
    output logic               mon_settled,
    output logic               osc_seen,
    output logic               clk_evt,
    output logic               sel_evt
);

    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic          wr_ctl;
    logic          wr_sel;
    logic          en_q;
    logic          sel_q;
    logic          osc_q;
    logic [SW-1:0] settle_q;

    // Decode the register writes.
    always_comb begin
        wr_ctl = wr_en && (addr == ADDR_MONCTL);
        wr_sel = wr_en && (addr == ADDR_SRCSEL);
    end

    // Monitor enable: comes up set after power-on, then written through bit 7.
    always_ff @(posedge clk) begin
        if (!por_n)      en_q <= 1'b1;
        else if (wr_ctl) en_q <= wdata[7];
    end

    // Monitor select: comes up set after power-on, then written through bit 0.
    always_ff @(posedge clk) begin
        if (!por_n)      sel_q <= 1'b1;
        else if (wr_sel) sel_q <= wdata[0];
    end

    // Settling timer: loaded on a 0->1 enable write, cleared on disable.
    always_ff @(posedge clk) begin
        if (!por_n)
            settle_q <= '0;
        else if (wr_ctl && wdata[7] && !en_q)
            settle_q <= SW'(SETTLE_CYC);
        else if (wr_ctl && !wdata[7])
            settle_q <= '0;
        else if (settle_q != '0)
            settle_q <= settle_q - 1'b1;
    end

    // Sticky flag: the oscillator has completed initialization.
    always_ff @(posedge clk) begin
        if (!por_n)         osc_q <= 1'b0;
        else if (osc_ready) osc_q <= 1'b1;
    end

    // Event generation and the status outputs.
    always_comb begin
        sel_evt     = wr_sel && wdata[0] && !sel_q && (settle_q != '0);
        clk_evt     = osc_q && clk_fail;
        mon_en      = en_q;
        mon_sel     = sel_q;
        mon_settled = (settle_q == '0);
        osc_seen    = osc_q;
    end

    // Read mux: reserved and unused bits read zero.
    always_comb begin
        case (addr)
            ADDR_MONCTL: rdata = {en_q, en_q & sup_ok, 6'b0};
            ADDR_SRCSEL: rdata = {7'b0, sel_q};
            ADDR_CAUSE:  rdata = {{(8 - CAUSE_W){1'b0}}, cause};
            default:     rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rst_seq_holdoff.sv
// Module: rst_seq_holdoff
// Picks the winning reset cause, loads that cause's hold-off length into
// one shared down-counter, and records the cause in a sticky one-hot
// register. Assumes a cause that is present in a cycle restarts the count.
module rst_seq_holdoff
    import rst_seq_pkg::*;
#(
    parameter int POR_CYC  = 1024,
    parameter int PIN_CYC  = 400,
    parameter int CLKF_CYC = 100000
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               clk_evt,
    input  logic               sel_evt,
    input  logic               pin_low,
    input  logic               sup_low,
    output logic               any_now,
    output logic               busy,
    output logic [CAUSE_W-1:0] cause_q
);

    localparam int CLK_LEN = CLKF_CYC + POR_CYC;
    localparam int MAXL    = max3(CLK_LEN, PIN_CYC, POR_CYC);
    localparam int CW      = $clog2(MAXL + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] win_len;
    src_e          win_src;

    // Fixed priority: clock failure, unsettled select, pin, supply.
    always_comb begin
        any_now = clk_evt | sel_evt | pin_low | sup_low;
        win_src = SRC_MON;
        win_len = '0;
        if (clk_evt) begin
            win_src = SRC_CLK;
            win_len = CW'(CLK_LEN);
        end else if (sel_evt) begin
            win_src = SRC_MON;
            win_len = CW'(POR_CYC);
        end else if (pin_low) begin
            win_src = SRC_PIN;
            win_len = CW'(PIN_CYC);
        end else begin
            win_src = SRC_MON;
            win_len = '0;
        end
    end

    // Shared hold-off counter: power-on preloads it, any cause reloads it.
    always_ff @(posedge clk) begin
        if (!por_n)
            cnt_q <= CW'(POR_CYC);
        else if (any_now)
            cnt_q <= win_len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Sticky cause: power-on sets the power-on bit, each later cause overwrites.
    always_ff @(posedge clk) begin
        if (!por_n)
            cause_q <= CAUSE_W'(1) << SRC_POR;
        else if (any_now)
            cause_q <= CAUSE_W'(1) << win_src;
    end

    // The counter is still running.
    always_comb busy = (cnt_q != '0);

endmodule

// File: rtl/rst_seq_release.sv
// Module: rst_seq_release
// Shift chain that releases reset a fixed number of clock edges after the
// hold request drops. Any hold request clears the whole chain at once.
module rst_seq_release #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic hold,
    output logic rel
);

    logic [STAGES-1:0] sh_q;

    // Shift ones in while no hold request is present.
    always_ff @(posedge clk) begin
        if (!por_n || hold) sh_q <= '0;
        else                sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end

    // The last stage is the release.
    always_comb rel = sh_q[STAGES-1];

endmodule

// File: rtl/rst_seq.sv
// Module: rst_seq (top)
// Combines power-on, supply monitor, clock failure and pin causes into
// one active-low system reset. Assertion is combinational; release goes
// through a two-stage shifter after each cause's hold-off count.
// Assumes sup_ok_i and the write port are synchronous to clk.
module rst_seq
    import rst_seq_pkg::*;
#(
    parameter int POR_CYC    = 1024,
    parameter int PIN_CYC    = 400,
    parameter int CLKF_CYC   = 100000,
    parameter int SETTLE_CYC = 2000
) (
    input  logic       clk,
    input  logic       por_n_i,
    input  logic       sup_ok_i,
    input  logic       osc_ready_i,
    input  logic       clk_fail_i,
    input  logic       pin_n_i,
    input  logic       wr_en_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       sys_rst_n_o
);

    logic               mon_en;
    logic               mon_sel;
    logic               mon_settled;
    logic               osc_seen;
    logic               clk_evt;
    logic               sel_evt;
    logic               pin_low;
    logic               sup_low;
    logic               any_now;
    logic               busy;
    logic               rel;
    logic [CAUSE_W-1:0] cause_q;

    // Qualify the level causes.
    always_comb begin
        pin_low = !pin_n_i;
        sup_low = mon_en && mon_sel && mon_settled && !sup_ok_i;
    end

    rst_seq_ctrl #(
        .SETTLE_CYC (SETTLE_CYC)
    ) ctrl_i (
        .clk         (clk),
        .por_n       (por_n_i),
        .wr_en       (wr_en_i),
        .addr        (addr_i),
        .wdata       (wdata_i),
        .sup_ok      (sup_ok_i),
        .osc_ready   (osc_ready_i),
        .clk_fail    (clk_fail_i),
        .cause       (cause_q),
        .rdata       (rdata_o),
        .mon_en      (mon_en),
        .mon_sel     (mon_sel),
        .mon_settled (mon_settled),
        .osc_seen    (osc_seen),
        .clk_evt     (clk_evt),
        .sel_evt     (sel_evt)
    );

    rst_seq_holdoff #(
        .POR_CYC  (POR_CYC),
        .PIN_CYC  (PIN_CYC),
        .CLKF_CYC (CLKF_CYC)
    ) hold_i (
        .clk     (clk),
        .por_n   (por_n_i),
        .clk_evt (clk_evt),
        .sel_evt (sel_evt),
        .pin_low (pin_low),
        .sup_low (sup_low),
        .any_now (any_now),
        .busy    (busy),
        .cause_q (cause_q)
    );

    rst_seq_release #(
        .STAGES (2)
    ) rel_i (
        .clk   (clk),
        .por_n (por_n_i),
        .hold  (any_now | busy),
        .rel   (rel)
    );

    // Asynchronous assertion, synchronous release.
    always_comb sys_rst_n_o = rel && !any_now && por_n_i;

endmodule

// File: rtl/rst_seq_chk.sv
// Module: rst_seq_chk
// Checker bound to rst_seq. Relates the ports to the internal cause
// signals over time.
module rst_seq_chk (
    input logic       clk,
    input logic       por_n_i,
    input logic       sup_ok_i,
    input logic       clk_fail_i,
    input logic       pin_n_i,
    input logic       sys_rst_n_o,
    input logic       mon_en,
    input logic       mon_sel,
    input logic       mon_settled,
    input logic       osc_seen,
    input logic       sel_evt,
    input logic       busy,
    input logic [3:0] cause_q
);

    p_por_holds_r1: assert property (@(posedge clk)
        !por_n_i |-> !sys_rst_n_o);

    p_por_config_r1: assert property (@(posedge clk) disable iff (!por_n_i)
        $past(!por_n_i) |-> (mon_en && mon_sel && cause_q == 4'b0001));

    p_supply_low_r2: assert property (@(posedge clk) disable iff (!por_n_i)
        (mon_en && mon_sel && mon_settled && !sup_ok_i) |-> !sys_rst_n_o);

    p_clkfail_gated_r4: assert property (@(posedge clk) disable iff (!por_n_i)
        (clk_fail_i && !osc_seen && pin_n_i && $stable(cause_q) && !busy && !sel_evt
         && (sup_ok_i || !mon_en || !mon_sel || !mon_settled)) |=> $stable(cause_q));

    p_pin_async_r11: assert property (@(posedge clk) disable iff (!por_n_i)
        !pin_n_i |-> !sys_rst_n_o);

    p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!por_n_i)
        $countones(cause_q) == 1);

    p_unsettled_sel_r8: assert property (@(posedge clk) disable iff (!por_n_i)
        sel_evt |=> !sys_rst_n_o);

    p_release_idle_r9: assert property (@(posedge clk) disable iff (!por_n_i)
        sys_rst_n_o |-> !busy);

endmodule

bind rst_seq rst_seq_chk chk_i (
    .clk         (clk),
    .por_n_i     (por_n_i),
    .sup_ok_i    (sup_ok_i),
    .clk_fail_i  (clk_fail_i),
    .pin_n_i     (pin_n_i),
    .sys_rst_n_o (sys_rst_n_o),
    .mon_en      (mon_en),
    .mon_sel     (mon_sel),
    .mon_settled (mon_settled),
    .osc_seen    (osc_seen),
    .sel_evt     (sel_evt),
    .busy        (busy),
    .cause_q     (cause_q)
);

// File: tb/rst_seq_tb_top.sv
// Bench for rst_seq with small hold-off lengths. Inputs are driven 1 ns
// after each falling edge and outputs are sampled there.
module rst_seq_tb_top;

    localparam int POR  = 6;
    localparam int PIN  = 4;
    localparam int CLKF = 10;
    localparam int SET  = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sup_ok = 1'b1;
    logic       osc_ready = 1'b0;
    logic       clk_fail = 1'b0;
    logic       pin_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rst_seq #(
        .POR_CYC    (POR),
        .PIN_CYC    (PIN),
        .CLKF_CYC   (CLKF),
        .SETTLE_CYC (SET)
    ) dut_i (
        .clk         (clk),
        .por_n_i     (por_n),
        .sup_ok_i    (sup_ok),
        .osc_ready_i (osc_ready),
        .clk_fail_i  (clk_fail),
        .pin_n_i     (pin_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .sys_rst_n_o (rst_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic wait_rel(output int n);
        n = 0;
        while (!rst_n && n < 300) begin
            step(1);
            n++;
        end
    endtask

    int v;
    int n;

    initial begin
        step(1);
        chk("R1 reset low during por", int'(rst_n), 0);
        step(3);
        por_n = 1'b1;
        wait_rel(n);
        chk("R1 por release edges", n, POR + 2);
        rd(8'h13, v); chk("R1 monctl after por", v, 8'hC0);
        rd(8'h14, v); chk("R1 srcsel after por", v, 8'h01);
        rd(8'h15, v); chk("R1 cause after por", v, 8'h01);

        // R6: reserved bits ignored, status bit masked.
        wr(8'h13, 8'hBF);
        rd(8'h13, v); chk("R6 reserved bits ignored", v, 8'hC0);
        wr(8'h14, 8'h00);
        sup_ok = 1'b0;
        #1;
        rd(8'h13, v); chk("R6 status shows low supply", v, 8'h80);
        step(3);
        chk("R10 deselected monitor no reset", int'(rst_n), 1);
        wr(8'h13, 8'h00);
        wr(8'h14, 8'h01);
        step(3);
        chk("R10 disabled monitor no reset", int'(rst_n), 1);
        sup_ok = 1'b1;
        #1;
        rd(8'h13, v); chk("R6 status masked when disabled", v, 8'h00);

        // R8: sweep the select write over the settling window.
        for (int m = 0; m <= SET + 1; m++) begin
            wr(8'h14, 8'h00);
            wr(8'h13, 8'h00);
            wr(8'h13, 8'h80);
            step(m);
            wr(8'h14, 8'h01);
            if (m + 1 <= SET) begin
                chk("R8 unsettled select resets", int'(rst_n), 0);
                wait_rel(n);
                chk("R8 unsettled select release", n, POR + 2);
                rd(8'h15, v); chk("R8 cause monitor", v, 8'h02);
            end else begin
                chk("R8 settled select no reset", int'(rst_n), 1);
            end
        end

        // R2 and R11: supply low for several widths.
        for (int h = 1; h <= 3; h++) begin
            sup_ok = 1'b0;
            #1;
            chk("R11 supply asserts before edge", int'(rst_n), 0);
            step(h);
            sup_ok = 1'b1;
            wait_rel(n);
            chk("R2 supply release edges", n, 2);
            rd(8'h15, v); chk("R2 cause supply", v, 8'h02);
        end

        // R5 and R11: pin low for several widths.
        for (int h = 1; h <= 3; h++) begin
            pin_n = 1'b0;
            #1;
            chk("R11 pin asserts before edge", int'(rst_n), 0);
            step(h);
            pin_n = 1'b1;
            wait_rel(n);
            chk("R5 pin release edges", n, PIN + 2);
            rd(8'h15, v); chk("R5 cause pin", v, 8'h08);
        end

        // R9: retrigger the pin hold at every offset.
        for (int g = 1; g <= PIN; g++) begin
            pin_n = 1'b0; step(1); pin_n = 1'b1;
            step(g);
            pin_n = 1'b0; step(1); pin_n = 1'b1;
            wait_rel(n);
            chk("R9 pin restart release", n, PIN + 2);
        end

        // R4: clock failure before the oscillator is ready.
        clk_fail = 1'b1; step(2); clk_fail = 1'b0;
        chk("R4 early clock fail ignored", int'(rst_n), 1);
        rd(8'h15, v); chk("R4 cause unchanged", v, 8'h08);

        // R3: clock failure after the oscillator is ready.
        osc_ready = 1'b1; step(1); osc_ready = 1'b0;
        clk_fail = 1'b1; step(1); clk_fail = 1'b0;
        wait_rel(n);
        chk("R3 clock fail release edges", n, CLKF + POR + 2);
        rd(8'h15, v); chk("R3 cause clock", v, 8'h04);

        // R9: a pin cause reloads a running clock-failure hold.
        clk_fail = 1'b1; step(1); clk_fail = 1'b0;
        step(2);
        pin_n = 1'b0; step(1); pin_n = 1'b1;
        wait_rel(n);
        chk("R9 pin reloads clock hold", n, PIN + 2);

        // R7: read-only cause and unused select bits.
        wr(8'h15, 8'hFF);
        rd(8'h15, v); chk("R7 cause ignores write", v, 8'h08);
        wr(8'h14, 8'hFF);
        rd(8'h14, v); chk("R7 select upper bits zero", v, 8'h01);
        chk("R7 reselect no reset", int'(rst_n), 1);

        // R1: power-on again restores the configuration.
        wr(8'h13, 8'h00);
        wr(8'h14, 8'h00);
        por_n = 1'b0;
        step(2);
        por_n = 1'b1;
        wait_rel(n);
        chk("R1 second por release", n, POR + 2);
        rd(8'h13, v); chk("R1 monctl restored", v, 8'hC0);
        rd(8'h14, v); chk("R1 srcsel restored", v, 8'h01);
        rd(8'h15, v); chk("R1 cause por", v, 8'h01);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule